// File: doc/BRIEF.md
# Quad-word realignment read buffer

This block lets a sequential stream of 128-bit reads begin at an address that is not a multiple of a quad. Memory is only ever read in aligned quads (eight 16-bit halfwords). The buffer keeps the quad it fetched last. Each new aligned quad is joined to that held quad, and the requested 128-bit window is cut out at the start offset.

All addresses are in halfword (16-bit) units. In word mode the offset inside a quad is taken in 32-bit steps and address bit 0 is ignored. In short-word mode any halfword offset is accepted.

After a new start address is loaded, the first access only primes the buffer. From the second access onward, every accepted response produces one realigned quad on the output, flagged by a one-cycle valid pulse. Each access moves the fetch pointer forward by one quad, which is eight halfwords.

Top module: `quad_realign_buffer`

## Requirements
- R1: After reset, `outValid` and `memReq` are 0 and `outData` is all zeros.
- R2: Each accepted access raises `memReq` combinationally in the same cycle as `accessReq`. `memAddr` is the start address with its low 3 bits cleared, plus 8 for every earlier access since the last load.
- R3: The first response accepted after a load produces no `outValid` pulse.
- R4: For the second and later responses, `outValid` is 1 in the cycle after the accepted response and 0 in the cycle after that.
- R5: In word mode (`shortMode`=0), the output lane l (bits 16l+15:16l) of the n-th valid output holds the halfword at E + 8(n-1) + l. Here E is the start address with bit 0 cleared.
- R6: In short-word mode (`shortMode`=1), the same lane rule holds with E equal to the start address itself, so odd halfword offsets are realigned.
- R7: A start address whose low 3 bits are 0 gives a zero shift, so the first valid output is exactly the quad at the start address. The priming access is still required.
- R8: Asserting `loadStart` cancels any outstanding request and clears the held quad. The next response after the new load again only primes the buffer.
- R9: A response that arrives with no request outstanding is ignored: there is no `outValid` pulse and `outData` is unchanged.
- R10: While a request is outstanding, `accessReq` is ignored, `memReq` stays 0 and the pointer does not advance.
- R11: When `loadStart` and `accessReq` are asserted in the same cycle, the load wins and no request is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| loadStart | input | 1 | Load a new start address and mode; clears the buffer |
| startAddr | input | ADDR_W | Start halfword address |
| shortMode | input | 1 | 1: 16-bit realignment, 0: 32-bit realignment |
| accessReq | input | 1 | Request the next quad access |
| memReq | output | 1 | Memory read strobe for an aligned quad |
| memAddr | output | ADDR_W | Aligned halfword address of the requested quad |
| memRspValid | input | 1 | Memory response strobe |
| memRspData | input | QUAD_W | Aligned quad data; lane l is the halfword at memAddr+l |
| outValid | output | 1 | One-cycle flag for realigned output data |
| outData | output | QUAD_W | Realigned quad |

## Verification
A wrong offset register, or a wrong mode captured at load, shows on the very first valid output as lanes that are rotated or off by one halfword against the memory pattern. A primed flag that is stuck or not cleared shows one response after a load, as a valid pulse that appears too early or never appears. A pending flag that is wrong shows at once as a doubled or missing `memReq`, or as a stray response being taken. A pointer that drifts shows on the next `memAddr`.

// File: rtl/quad_realign_pkg.sv
package quad_realign_pkg;
  typedef struct packed {
    logic load;     // new start: clear held quad, capture offset
    logic capture;  // accepted memory response
  } realignStrobes_t;
endpackage

// File: rtl/realign_ctrl.sv
module realign_ctrl
  import quad_realign_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int QUAD_LANES = 8
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic                                 loadStart,
  input  logic [ADDR_W-1:$clog2(QUAD_LANES)]   startBase,
  input  logic                                 accessReq,
  input  logic                                 memRspValid,
  output logic                                 memReq,
  output logic [ADDR_W-1:0]                    memAddr,
  output logic                                 outValid,
  output realignStrobes_t                      strobes
);
  localparam int OFF_W = $clog2(QUAD_LANES);

  logic [ADDR_W-1:0] ptrQ;
  logic pendingQ, primedQ, validQ;
  logic issue, accept;

  assign issue  = accessReq && !pendingQ && !loadStart;
  assign accept = memRspValid && pendingQ && !loadStart;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrQ     <= '0;
      pendingQ <= 1'b0;
      primedQ  <= 1'b0;
      validQ   <= 1'b0;
    end else if (loadStart) begin
      ptrQ     <= {startBase, {OFF_W{1'b0}}};
      pendingQ <= 1'b0;
      primedQ  <= 1'b0;
      validQ   <= 1'b0;
    end else begin
      validQ <= accept && primedQ;
      if (issue) begin
        ptrQ     <= ptrQ + ADDR_W'(QUAD_LANES);
        pendingQ <= 1'b1;
      end
      if (accept) begin
        pendingQ <= 1'b0;
        primedQ  <= 1'b1;
      end
    end
  end

  assign memReq           = issue;
  assign memAddr          = ptrQ;
  assign outValid         = validQ;
  assign strobes.load     = loadStart;
  assign strobes.capture  = accept;

  a_r2_addr_aligned: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (memAddr[OFF_W-1:0] == '0));
  a_r10_no_req_while_pending: assert property (@(posedge clk) disable iff (!rstN)
    pendingQ |-> !memReq);
  a_r3_prime_no_valid: assert property (@(posedge clk) disable iff (!rstN)
    $rose(primedQ) |-> !outValid);
  a_r4_valid_follows_rsp: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(memRspValid && pendingQ));
  a_r8_load_clears: assert property (@(posedge clk) disable iff (!rstN)
    $past(loadStart) |-> (!outValid && !pendingQ && !primedQ));
  a_r11_load_wins: assert property (@(posedge clk) disable iff (!rstN)
    loadStart |-> !memReq);
endmodule

// File: rtl/realign_datapath.sv
module realign_datapath
  import quad_realign_pkg::*;
#(
  parameter int QUAD_W = 128,
  parameter int LANE_W = 16
) (
  input  logic                                    clk,
  input  logic                                    rstN,
  input  realignStrobes_t                         strobes,
  input  logic [$clog2(QUAD_W/LANE_W)-1:0]        startLow,
  input  logic                                    shortMode,
  input  logic [QUAD_W-1:0]                       memRspData,
  output logic [QUAD_W-1:0]                       outData
);
  localparam int LANES = QUAD_W / LANE_W;
  localparam int OFF_W = $clog2(LANES);

  logic [OFF_W-1:0]  offQ;
  logic [QUAD_W-1:0] prevQ, dataQ, window;
  logic [LANE_W-1:0] pairLanes [2*LANES];

  // Older quad in the low lanes, newer quad above it
  for (genvar p = 0; p < LANES; p++) begin : g_pair
    assign pairLanes[p]         = prevQ[p*LANE_W +: LANE_W];
    assign pairLanes[p + LANES] = memRspData[p*LANE_W +: LANE_W];
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [OFF_W:0] sel;
    assign sel = {1'b0, offQ} + (OFF_W+1)'(l);
    assign window[l*LANE_W +: LANE_W] = pairLanes[sel];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      offQ  <= '0;
      prevQ <= '0;
      dataQ <= '0;
    end else if (strobes.load) begin
      offQ  <= shortMode ? startLow : {startLow[OFF_W-1:1], 1'b0};
      prevQ <= '0;
      dataQ <= '0;
    end else if (strobes.capture) begin
      prevQ <= memRspData;
      dataQ <= window;
    end
  end

  assign outData = dataQ;

  a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.capture && !strobes.load) |=> $stable(outData));
  a_r8_load_zeroes: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> (outData == '0));
endmodule

// File: rtl/quad_realign_buffer.sv
module quad_realign_buffer
  import quad_realign_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int QUAD_W = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadStart,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic              shortMode,
  input  logic              accessReq,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memRspValid,
  input  logic [QUAD_W-1:0] memRspData,
  output logic              outValid,
  output logic [QUAD_W-1:0] outData
);
  localparam int LANE_W = 16;
  localparam int LANES  = QUAD_W / LANE_W;
  localparam int OFF_W  = $clog2(LANES);

  realignStrobes_t strobes;

  realign_ctrl #(.ADDR_W(ADDR_W), .QUAD_LANES(LANES)) u_ctrl (
    .clk(clk), .rstN(rstN), .loadStart(loadStart),
    .startBase(startAddr[ADDR_W-1:OFF_W]), .accessReq(accessReq),
    .memRspValid(memRspValid), .memReq(memReq), .memAddr(memAddr),
    .outValid(outValid), .strobes(strobes)
  );

  realign_datapath #(.QUAD_W(QUAD_W), .LANE_W(LANE_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .startLow(startAddr[OFF_W-1:0]), .shortMode(shortMode),
    .memRspData(memRspData), .outData(outData)
  );
endmodule

// File: tb/sim_quad_realign_buffer.sv
module sim_quad_realign_buffer;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0;
  logic loadStart = 0, shortMode = 0, accessReq = 0, memRspValid = 0;
  logic [31:0] startAddr = '0;
  logic [127:0] memRspData = '0;
  logic memReq, outValid;
  logic [31:0] memAddr;
  logic [127:0] outData;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [31:0] baseQ, effStart;
  int idx;

  always #(CLK_PERIOD/2) clk = ~clk;

  quad_realign_buffer u0 (.*);

  function automatic logic [15:0] memHalf(logic [31:0] a);
    logic [31:0] t = a * 32'h9E37 ^ 32'h5A5A_1234;
    return t[15:0] ^ t[31:16];
  endfunction

  function automatic logic [127:0] quadAt(logic [31:0] a);
    logic [127:0] q;
    for (int l = 0; l < 8; l++) q[l*16 +: 16] = memHalf(a + 32'(l));
    return q;
  endfunction

  task automatic check(bit ok, string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doLoad(logic [31:0] a, logic sm);
    @(negedge clk);
    loadStart = 1; startAddr = a; shortMode = sm;
    @(negedge clk);
    loadStart = 0;
    baseQ = {a[31:3], 3'b000};
    effStart = sm ? a : {a[31:1], 1'b0};
    idx = 0;
  endtask

  // One access: request, respond, check output
  task automatic doAccess(string tag);
    logic [31:0] a;
    logic [127:0] prevOut;
    @(negedge clk);
    accessReq = 1;
    #1;
    check(memReq == 1'b1, "R2 memReq raised", 128'(memReq), 128'd1);
    check(memAddr == baseQ + 32'(8*idx), "R2 memAddr", 128'(memAddr), 128'(baseQ + 32'(8*idx)));
    a = memAddr;
    @(negedge clk);
    accessReq = 0;
    prevOut = outData;
    memRspValid = 1; memRspData = quadAt(a);
    @(negedge clk);
    memRspValid = 0;
    #1;
    if (idx == 0) begin
      check(outValid == 1'b0, {tag, " R3 priming gives no valid"}, 128'(outValid), 128'd0);
    end else begin
      check(outValid == 1'b1, {tag, " R4 valid after rsp"}, 128'(outValid), 128'd1);
      check(outData == quadAt(effStart + 32'(8*(idx-1))), {tag, " data window"},
            outData, quadAt(effStart + 32'(8*(idx-1))));
    end
    @(negedge clk);
    #1;
    check(outValid == 1'b0, {tag, " R4 valid lasts one cycle"}, 128'(outValid), 128'd0);
    if (prevOut === 'x) check(0, "unknown", prevOut, '0);
    idx++;
  endtask

  task automatic testReset();
    #1;
    check(outValid == 0 && memReq == 0, "R1 reset flags", {126'd0, outValid, memReq}, '0);
    check(outData == '0, "R1 reset data", outData, '0);
  endtask

  task automatic testWord();
    doLoad(32'h0000_0103, 1'b0);
    for (int k = 0; k < 4; k++) doAccess("R5 word mode");
  endtask

  task automatic testShort();
    doLoad(32'h0000_0205, 1'b1);
    for (int k = 0; k < 4; k++) doAccess("R6 short mode");
  endtask

  task automatic testAligned();
    doLoad(32'h0000_0300, 1'b0);
    doAccess("R7 aligned");
    doAccess("R7 aligned");
  endtask

  task automatic testReload();
    logic [127:0] held;
    doLoad(32'h0000_0400, 1'b1);
    doAccess("R8 first stream");
    doAccess("R8 first stream");
    @(negedge clk); accessReq = 1;          // request left outstanding
    @(negedge clk); accessReq = 0;
    doLoad(32'h0000_0503, 1'b1);
    #1;
    check(outData == '0, "R8 load clears output", outData, '0);
    held = outData;
    memRspValid = 1; memRspData = quadAt(32'h0000_0408); // late response
    @(negedge clk); memRspValid = 0;
    #1;
    check(outValid == 0, "R8 cancelled request not taken", 128'(outValid), '0);
    check(outData == held, "R9 late rsp leaves data", outData, held);
    doAccess("R8 primes again");
    doAccess("R8 new stream");
  endtask

  task automatic testSpurious();
    logic [127:0] held;
    doLoad(32'h0000_0611, 1'b1);
    doAccess("R9 setup");
    doAccess("R9 setup");
    held = outData;
    @(negedge clk);
    memRspValid = 1; memRspData = ~quadAt(32'h0);
    @(negedge clk);
    memRspValid = 0;
    #1;
    check(outValid == 0, "R9 stray rsp no valid", 128'(outValid), '0);
    check(outData == held, "R9 stray rsp data held", outData, held);
    doAccess("R9 stream intact");
  endtask

  task automatic testBusy();
    doLoad(32'h0000_0702, 1'b0);
    @(negedge clk); accessReq = 1;
    #1;
    check(memReq == 1 && memAddr == 32'h700, "R10 first request", {95'd0, memReq, memAddr}, {95'd0, 1'b1, 32'h700});
    @(negedge clk);
    #1;
    check(memReq == 0, "R10 held req ignored", 128'(memReq), '0);
    @(negedge clk); accessReq = 0;
    memRspValid = 1; memRspData = quadAt(32'h700);
    @(negedge clk); memRspValid = 0;
    idx = 1;
    doAccess("R10 pointer advanced once");
  endtask

  task automatic testLoadWins();
    doLoad(32'h0000_0800, 1'b0);
    @(negedge clk);
    loadStart = 1; accessReq = 1; startAddr = 32'h0000_0907; shortMode = 1;
    #1;
    check(memReq == 0, "R11 load beats access", 128'(memReq), '0);
    @(negedge clk);
    loadStart = 0; accessReq = 0;
    baseQ = 32'h900; effStart = 32'h907; idx = 0;
    doAccess("R11 after load");
    doAccess("R11 after load");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    testReset();
    testWord();
    testShort();
    testAligned();
    testReload();
    testSpurious();
    testBusy();
    testLoadWins();
    repeat (2) @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule